// File: doc/BRIEF.md
# Tape Mode Identification Timer

This block measures how fast a tape is moving relative to its control track so that software can decide which recording speed mode a tape was made in. Three small timer units cooperate. The first divides the control-track frequency pulse stream (cfgIn) by a programmable ratio. The second counts the outputs of that divider. The third divides the control pulse stream (dvctlIn) to form a measurement window. At the end of each window, the second unit's count is copied into the capture register and the unit restarts from zero. The captured number is the count of divided CFG events seen during a programmable number of DVCTL periods. The block comes out of reset already set up for this measurement, with both divide ratios at 1.

A second arrangement, selected by `reelMode`, joins the first two units into one 16-bit up-counter of CFG edges. Each rising edge of the interrupt input `irqIn` captures that counter and clears it. Software can therefore count CFG pulses over the length of a reel pulse. All three pulse inputs pass through a two-flop synchronizer and a rising-edge detector before they reach any counter.

Top module: `tapeModeTimer`

## Requirements
- R1: After reset, capValue is 0, capDone is 0 and capOverrun is 0, and both reload values are 1.
- R2: Each rising edge of cfgIn, dvctlIn or irqIn counts once, however long the input then stays high. The edge takes effect on the counters on the second clock edge after the one that first samples it high.
- R3: With reelMode=0, the CFG divider underflows once every N CFG edges, where N is its reload value (0 acts as 1). A write with wrSel=0 sets N and also restarts the divider at N.
- R4: With reelMode=0, a capture happens once every M DVCTL edges, where M is the window reload value (0 acts as 1). A write with wrSel=1 sets M and also restarts the window divider at M.
- R5: With reelMode=0, a capture loads capValue[7:0] with the number of CFG divider underflows since the previous capture and loads capValue[15:8] with 0. An underflow in the same clock as the capture is counted in the next window.
- R6: With reelMode=0, the underflow count wraps modulo 256.
- R7: With reelMode=1, every CFG edge increments a 16-bit counter. Each irqIn rising edge loads the counter into capValue[15:0] and clears it, and a CFG edge in that same clock is counted in the next window. DVCTL edges cause no capture.
- R8: With reelMode=0, irqIn edges cause no capture.
- R9: Any change of reelMode restarts the counters. The CFG side restarts at its reload value in mode 0 or at 0 in mode 1, the underflow count restarts at 0, and the window divider restarts at its reload value.
- R10: capDone sets on each capture and clears in the clock after rdStrobe. A capture in the same clock as rdStrobe leaves capDone set.
- R11: A capture while capDone is set and rdStrobe is low sets capOverrun. rdStrobe clears capOverrun.
- R12: capValue changes only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgIn | input | 1 | Control-track frequency pulse, asynchronous |
| dvctlIn | input | 1 | Control pulse, asynchronous |
| irqIn | input | 1 | External interrupt pulse used as the capture trigger in reel mode |
| reelMode | input | 1 | 0: mode identification, 1: 16-bit reel count |
| wrEn | input | 1 | Reload write strobe |
| wrSel | input | 1 | 0: CFG divider reload, 1: window divider reload |
| wrData | input | CNT_W | Reload value |
| rdStrobe | input | 1 | Capture register read, clears the flags |
| capValue | output | 2*CNT_W | Capture register |
| capDone | output | 1 | Capture-done flag |
| capOverrun | output | 1 | A capture arrived before the previous one was read |

## Verification
The assertions check the rules that hold on every clock. A rising-edge detector never fires on two consecutive clocks. An underflow always reloads the divider. Each capture clears the window count and, in mode 0, zeroes the upper capture byte. The flags follow capture and read, overrun never stands without done, and capValue holds between captures. Only the bench's scenarios can show that the counts are correct. These scenarios cover the divide ratios, the 8-bit wrap, a CFG edge that coincides with a capture, a read in the capture clock, the 16-bit carry in reel mode and the restart on a mode change. A behavioural model is compared with the outputs on every clock.

// File: rtl/tmtPkg.sv
package tmtPkg;
  typedef struct packed {
    logic cfgTick;   // CFG edge reached the counters
    logic winTick;   // DVCTL edge in mode-identification arrangement
    logic reelTick;  // interrupt edge in reel arrangement
    logic restart;   // arrangement changed this clock
    logic reelOn;    // current arrangement
  } tmtStrobe_t;
endpackage

// File: rtl/tmtEdgeSync.sv
module tmtEdgeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic evt
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign evt = pipe[STAGES-1] & ~pipe[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    evt |=> !evt); // R2
endmodule

// File: rtl/tmtCtrl.sv
module tmtCtrl
  import tmtPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgIn,
  input  logic       dvctlIn,
  input  logic       irqIn,
  input  logic       reelMode,
  output tmtStrobe_t stb
);
  localparam int NUM_IN = 3;
  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] evt;
  logic              modeQ;
  logic              restart;

  assign rawIn = {irqIn, dvctlIn, cfgIn};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    tmtEdgeSync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawIn[i]),
      .evt (evt[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= reelMode;
  end

  assign restart = reelMode ^ modeQ;

  always_comb begin
    stb.restart  = restart;
    stb.reelOn   = reelMode;
    stb.cfgTick  = evt[0] & ~restart;
    stb.winTick  = evt[1] & ~reelMode & ~restart;
    stb.reelTick = evt[2] & reelMode & ~restart;
  end
endmodule

// File: rtl/tmtDatapath.sv
module tmtDatapath
  import tmtPkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RLD_RST = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmtStrobe_t         stb,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               rdStrobe,
  output logic [2*CNT_W-1:0] capValue,
  output logic               capDone,
  output logic               capOverrun
);
  localparam int CAP_W = 2 * CNT_W;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] RLD_IV = CNT_W'(RLD_RST);

  logic [CNT_W-1:0] rld1, rld3, cnt1, cnt2, cnt3;
  logic             wr1, wr3, uf1, uf3, capEvt;
  logic [CAP_W-1:0] capSrc;

  assign wr1    = wrEn & ~wrSel;
  assign wr3    = wrEn & wrSel;
  assign uf1    = stb.cfgTick & ~stb.reelOn & ~wr1 & (cnt1 <= ONE);
  assign uf3    = stb.winTick & ~wr3 & (cnt3 <= ONE);
  assign capEvt = uf3 | stb.reelTick;
  assign capSrc = stb.reelOn ? {cnt2, cnt1} : {{CNT_W{1'b0}}, cnt2};

  // reload registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rld1 <= RLD_IV;
      rld3 <= RLD_IV;
    end else begin
      if (wr1) rld1 <= wrData;
      if (wr3) rld3 <= wrData;
    end
  end

  // CFG divider, or low half of the reel counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt1 <= RLD_IV;
    else if (stb.restart)     cnt1 <= stb.reelOn ? '0 : rld1;
    else if (stb.reelOn) begin
      if (stb.reelTick)       cnt1 <= stb.cfgTick ? ONE : '0;
      else if (stb.cfgTick)   cnt1 <= cnt1 + ONE;
    end
    else if (wr1)             cnt1 <= wrData;
    else if (stb.cfgTick)     cnt1 <= uf1 ? rld1 : cnt1 - ONE;
  end

  // underflow count, or high half of the reel counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt2 <= '0;
    else if (stb.restart)     cnt2 <= '0;
    else if (stb.reelOn) begin
      if (stb.reelTick)                      cnt2 <= '0;
      else if (stb.cfgTick && (cnt1 == '1))  cnt2 <= cnt2 + ONE;
    end
    else if (uf3)             cnt2 <= uf1 ? ONE : '0;
    else if (uf1)             cnt2 <= cnt2 + ONE;
  end

  // window divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt3 <= RLD_IV;
    else if (stb.restart)     cnt3 <= rld3;
    else if (wr3)             cnt3 <= wrData;
    else if (stb.winTick)     cnt3 <= uf3 ? rld3 : cnt3 - ONE;
  end

  // capture register and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValue   <= '0;
      capDone    <= 1'b0;
      capOverrun <= 1'b0;
    end else begin
      if (capEvt) capValue <= capSrc;
      if (rdStrobe) begin
        capDone    <= capEvt;
        capOverrun <= 1'b0;
      end else if (capEvt) begin
        capDone    <= 1'b1;
        capOverrun <= capOverrun | capDone;
      end
    end
  end

  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    uf1 |=> (cnt1 == $past(rld1))); // R3
  AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    uf3 |=> (cnt2 <= ONE)); // R5
  AST_ID_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (capEvt && !stb.reelOn) |=> (capValue[CAP_W-1:CNT_W] == '0)); // R5
  AST_DONE_ON_CAP: assert property (@(posedge clk) disable iff (!rstN)
    capEvt |=> capDone); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !capEvt) |=> (!capDone && !capOverrun)); // R10
  AST_OVR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    capOverrun |-> capDone); // R11
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !capEvt |=> $stable(capValue)); // R12
endmodule

// File: rtl/tapeModeTimer.sv
module tapeModeTimer
  import tmtPkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int RLD_RST     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgIn,
  input  logic               dvctlIn,
  input  logic               irqIn,
  input  logic               reelMode,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               rdStrobe,
  output logic [2*CNT_W-1:0] capValue,
  output logic               capDone,
  output logic               capOverrun
);
  tmtStrobe_t stb;

  tmtCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgIn   (cfgIn),
    .dvctlIn (dvctlIn),
    .irqIn   (irqIn),
    .reelMode(reelMode),
    .stb     (stb)
  );

  tmtDatapath #(.CNT_W(CNT_W), .RLD_RST(RLD_RST)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .rdStrobe  (rdStrobe),
    .capValue  (capValue),
    .capDone   (capDone),
    .capOverrun(capOverrun)
  );
endmodule

// File: tb/tapeModeTimer_bench.sv
module tapeModeTimer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgIn = 1'b0, dvctlIn = 1'b0, irqIn = 1'b0, reelMode = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0, rdStrobe = 1'b0;
  logic [CNT_W-1:0] wrData = '0;
  logic [2*CNT_W-1:0] capValue;
  logic capDone, capOverrun;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tapeModeTimer #(.CNT_W(CNT_W)) u_tapeModeTimer (
    .clk(clk), .rstN(rstN), .cfgIn(cfgIn), .dvctlIn(dvctlIn), .irqIn(irqIn),
    .reelMode(reelMode), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdStrobe(rdStrobe), .capValue(capValue), .capDone(capDone),
    .capOverrun(capOverrun)
  );

  // behavioural reference model: input history per source, integer counters
  bit hc[3], hd[3], hi[3];
  int mRl1, mRl3, mC1, mC2, mC3, mCap;
  bit mDone, mOvr, mModeQ;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hc = '{0,0,0}; hd = '{0,0,0}; hi = '{0,0,0};
      mRl1 = 1; mRl3 = 1; mC1 = 1; mC2 = 0; mC3 = 1; mCap = 0;
      mDone = 0; mOvr = 0; mModeQ = 0;
    end else begin
      bit cE, dE, iE, rs, md, w1, w3, u1, u3, cap;
      int full, capNew;
      cE = hc[1] & ~hc[2];
      dE = hd[1] & ~hd[2];
      iE = hi[1] & ~hi[2];
      hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = cfgIn;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = dvctlIn;
      hi[2] = hi[1]; hi[1] = hi[0]; hi[0] = irqIn;
      md = reelMode;
      rs = (md != mModeQ);
      mModeQ = md;
      w1 = wrEn && !wrSel;
      w3 = wrEn && wrSel;
      cap = 0; capNew = 0;
      if (rs) begin
        mC1 = md ? 0 : mRl1; mC2 = 0; mC3 = mRl3;
      end else if (md) begin
        full = mC2 * 256 + mC1;
        if (iE) begin
          cap = 1; capNew = full; full = cE ? 1 : 0;
        end else if (cE) full = (full + 1) % 65536;
        mC1 = full % 256; mC2 = full / 256;
        if (w3) mC3 = wrData;
      end else begin
        u1 = cE && !w1 && (mC1 <= 1);
        u3 = dE && !w3 && (mC3 <= 1);
        if (w1) mC1 = wrData;
        else if (cE) mC1 = u1 ? mRl1 : mC1 - 1;
        if (u3) begin
          cap = 1; capNew = mC2; mC2 = u1 ? 1 : 0;
        end else if (u1) mC2 = (mC2 + 1) % 256;
        if (w3) mC3 = wrData;
        else if (dE) mC3 = u3 ? mRl3 : mC3 - 1;
      end
      if (w1) mRl1 = wrData;
      if (w3) mRl3 = wrData;
      if (cap) mCap = capNew;
      if (rdStrobe) begin
        mDone = cap; mOvr = 0;
      end else if (cap) begin
        mOvr = mOvr | mDone; mDone = 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check({phase, " capValue per-cycle"}, int'(capValue), mCap);
      check({phase, " capDone per-cycle"}, int'(capDone), int'(mDone));
      check({phase, " capOverrun per-cycle"}, int'(capOverrun), int'(mOvr));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 cfg, 1 dvctl, 2 irq, 3 cfg and dvctl together
  task automatic pulse(input int which, input int highCyc = 3);
    @(negedge clk);
    if (which == 0 || which == 3) cfgIn = 1'b1;
    if (which == 1 || which == 3) dvctlIn = 1'b1;
    if (which == 2) irqIn = 1'b1;
    idle(highCyc);
    cfgIn = 1'b0; dvctlIn = 1'b0; irqIn = 1'b0;
    idle(3);
  endtask

  task automatic cfgPulses(input int n);
    for (int i = 0; i < n; i++) pulse(0);
  endtask

  task automatic writeReload(input bit sel, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = CNT_W'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCap();
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 capValue", int'(capValue), 0);
    check("R1 capDone", int'(capDone), 0);
    check("R1 capOverrun", int'(capOverrun), 0);

    // R5 default ratios of 1: three CFG edges in one window
    phase = "R5";
    cfgPulses(3);
    pulse(1);
    check("R5 count with default ratios", int'(capValue), 3);
    check("R10 done after capture", int'(capDone), 1);
    readCap();
    check("R10 done cleared by read", int'(capDone), 0);

    // R2 a long high level counts once
    phase = "R2";
    pulse(0, 20);
    pulse(1);
    check("R2 long pulse counts once", int'(capValue), 1);
    readCap();

    // R3 and R4 divide ratios
    phase = "R3";
    writeReload(1'b0, 3);
    writeReload(1'b1, 2);
    cfgPulses(7);
    pulse(1);
    check("R4 no capture after one of two DVCTL edges", int'(capDone), 0);
    pulse(1);
    check("R3 seven CFG edges over ratio 3", int'(capValue), 2);
    readCap();

    // R8 interrupt ignored in mode identification
    phase = "R8";
    pulse(2);
    check("R8 irq causes no capture", int'(capDone), 0);
    check("R8 capValue unchanged", int'(capValue), 2);

    // R11 overrun
    phase = "R11";
    writeReload(1'b0, 1);
    writeReload(1'b1, 1);
    cfgPulses(2);
    pulse(1);
    cfgPulses(1);
    pulse(1);
    check("R11 second window value", int'(capValue), 1);
    check("R11 overrun set", int'(capOverrun), 1);
    readCap();
    check("R11 overrun cleared by read", int'(capOverrun), 0);

    // R6 wrap at 256
    phase = "R6";
    cfgPulses(258);
    pulse(1);
    check("R6 count wraps modulo 256", int'(capValue), 2);
    readCap();

    // R5 coincident underflow goes to the next window
    phase = "R5";
    cfgPulses(1);
    pulse(3);
    check("R5 coincident edge not in closing window", int'(capValue), 1);
    readCap();
    pulse(1);
    check("R5 coincident edge in next window", int'(capValue), 1);
    readCap();

    // R10 read in the capture clock
    phase = "R10";
    cfgPulses(2);
    @(negedge clk);
    dvctlIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    idle(2);
    dvctlIn = 1'b0;
    check("R10 capture with read keeps done", int'(capDone), 1);
    check("R10 captured value", int'(capValue), 2);
    readCap();
    check("R10 cleared", int'(capDone), 0);

    // R7 and R9 reel arrangement
    phase = "R9";
    cfgPulses(1);
    @(negedge clk);
    reelMode = 1'b1;
    idle(2);
    pulse(2);
    check("R9 reel counter starts at zero", int'(capValue), 0);
    readCap();
    phase = "R7";
    cfgPulses(300);
    pulse(1);
    check("R7 dvctl ignored in reel mode", int'(capDone), 0);
    pulse(2);
    check("R7 16-bit reel count", int'(capValue), 300);
    readCap();
    pulse(3);
    pulse(2);
    check("R7 reel count after clear", int'(capValue), 1);
    readCap();

    // R9 back to mode identification
    phase = "R9";
    cfgPulses(5);
    @(negedge clk);
    reelMode = 1'b0;
    idle(2);
    pulse(1);
    check("R9 count restarted on mode change", int'(capValue), 0);
    readCap();
    cfgPulses(1);
    pulse(1);
    check("R9 counting resumes", int'(capValue), 1);
    readCap();

    idle(5);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule